// File: doc/BRIEF.md
# SDRAM Initialization and Command Controller

This block sits between a simple host request port and a four-bank SDRAM device. After reset it waits a power-up interval, then brings the device up in a fixed order: all banks are precharged, two auto-refresh commands are issued, and the mode register is programmed. The mode word selects a burst of one, sequential ordering, the configured CAS latency and single-location writes. From then on the controller serves one host request at a time and keeps up periodic auto-refresh.

Each host transaction is an activate of the addressed bank and row, followed by one read or write to the column with auto-precharge requested. No row stays open between transactions. All device timing (row-to-column delay, row cycle, precharge, refresh cycle, mode-register recovery and write recovery) is held as clock counts in parameters. Every command is followed by a single gap counter that only lets the next command out after the required number of clocks. A refresh that falls due waits until the current transaction has finished, and then it wins over any new host request.

Read data is sampled from the device CAS-latency clocks after the read command. It is handed back with a one-cycle valid pulse. Host addresses are split as bank in the top bits, then row, then column in the low bits.

Top module: `sdc_ctrl`

## Requirements
- R1: While reset is held and until initialization ends, the command bus shows NOP (chip select low, RAS/CAS/WE high), `rsp_valid` is low and `req_ready` is low; `req_ready` is never high while `init_done` is low.
- R2: The first command after reset release is a precharge with address bit 10 high (all banks), issued no earlier than INIT_WAIT clocks after reset release.
- R3: Initialization issues exactly precharge-all, auto refresh, auto refresh, mode register set, in that order, with at least T_RP clocks after the precharge and T_RFC clocks after each refresh. Commands are encoded on {cs_n, ras_n, cas_n, we_n} as 0000 mode set, 0001 refresh, 0010 precharge, 0011 activate, 0100 write, 0101 read, 0111 NOP.
- R4: The mode register set command carries address 0x230 on the bus: burst length code 000 in bits 2:0, sequential in bit 3, CAS latency 3 in bits 6:4, 00 in bits 8:7, single-location write in bit 9, 00 in bits 11:10. The bank bits are 0.
- R5: `init_done` is high from the clock after the mode register set, and no activate follows it sooner than T_MRD clocks.
- R6: An activate carries bank = req_addr[21:20] and row = req_addr[19:8] of the accepted request. The read or write follows it no sooner than T_RCD clocks.
- R7: Every read and write carries address bit 10 high (auto-precharge), column = req_addr[7:0] in address bits 7:0, and the bank of the preceding activate.
- R8: Successive activates are at least T_RC clocks apart, and no activate follows a refresh sooner than T_RFC clocks.
- R9: A write drives `sd_dq_oe` high with the request data on `sd_dq_out` and `sd_dqm` equal to the inverted byte enables (mask bit i high blocks byte i). A read leaves `sd_dq_oe` low.
- R10: `rsp_valid` is high for exactly one clock, starting CAS_LAT clocks after the read command, with `rsp_rdata` equal to the data last written to that host address (0 if never written).
- R11: After initialization, auto-refresh commands occur once per REF_INTERVAL clocks, within one transaction plus a refresh of slack. A due refresh is issued before a new request that is already waiting.
- R12: A request is taken only in a clock where `req_valid` and `req_ready` are both high. Each taken request produces exactly one activate and one read or write of the requested kind.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller and device clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Controller takes the request this clock |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 22 | {bank, row, column} host address |
| req_wdata | input | 32 | Write data |
| req_be | input | 4 | Byte enables, bit i for byte i |
| rsp_valid | output | 1 | One-clock read data strobe |
| rsp_rdata | output | 32 | Returned read data |
| init_done | output | 1 | Initialization complete |
| sd_cs_n | output | 1 | Device chip select, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank select |
| sd_addr | output | 12 | Multiplexed row/column/mode address, bit 10 = auto-precharge / all banks |
| sd_dqm | output | 4 | Byte masks |
| sd_dq_out | output | 32 | Write data to the device |
| sd_dq_oe | output | 1 | Data output enable |
| sd_dq_in | input | 32 | Read data from the device |

## Verification
The assertions assume that the host holds `req_valid` and its request fields steady until a handshake clock, and that the device returns read data on `sd_dq_in` before the sampling edge CAS_LAT clocks after the read. The bench host task changes request fields only just after a rising edge. It keeps them until a falling-edge sample of `req_ready` confirms acceptance. The bench device model places data on the bus at the falling edge before the sampling edge. The refresh-wait bound assumes REF_INTERVAL is well above one transaction plus one refresh, which the bench parameters respect.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

  // {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_MRS = 4'b0000,
    CMD_REF = 4'b0001,
    CMD_PRE = 4'b0010,
    CMD_ACT = 4'b0011,
    CMD_WR  = 4'b0100,
    CMD_RD  = 4'b0101,
    CMD_BST = 4'b0110,
    CMD_NOP = 4'b0111
  } sdc_cmd_e;

  typedef enum logic [2:0] {
    ST_POWER,
    ST_REF_A,
    ST_REF_B,
    ST_MODE,
    ST_IDLE,
    ST_ACCESS
  } sdc_state_e;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // burst of one, sequential, given CAS latency, single-location writes
  function automatic logic [11:0] mode_word(input int cas_lat);
    logic [11:0] w;
    w      = '0;
    w[2:0] = 3'b000;
    w[3]   = 1'b0;
    w[6:4] = 3'(cas_lat);
    w[8:7] = 2'b00;
    w[9]   = 1'b1;
    return w;
  endfunction

  // clocks from a read/write with auto-precharge until the next command
  function automatic int access_gap(input int t_rc, input int t_rcd, input int t_ras,
                                    input int t_rp, input int t_wr, input int cas_lat,
                                    input bit is_write);
    int g;
    g = imax(t_rc - t_rcd, t_ras - t_rcd + t_rp);
    g = imax(g, is_write ? (t_wr + t_rp) : (cas_lat + 1));
    return g;
  endfunction

  // longest time a due refresh may wait
  function automatic int ref_wait_bound(input int t_rfc, input int t_rcd, input int gap);
    return t_rfc + t_rcd + gap + 2;
  endfunction

endpackage

// File: rtl/sdc_gap_timer.sv
module sdc_gap_timer #(
  parameter int W       = 8,
  parameter int RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= W'(RST_VAL);
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);
endmodule

// File: rtl/sdc_refresh_sched.sv
module sdc_refresh_sched #(
  parameter int INTERVAL = 1560
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic ack,
  output logic pending
);
  localparam int W = $clog2(INTERVAL + 1);
  logic [W-1:0] cnt;
  logic         tick;

  assign tick = enable && (cnt == W'(INTERVAL - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)       cnt <= '0;
    else if (!enable) cnt <= '0;
    else if (tick)    cnt <= '0;
    else              cnt <= cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    pending <= 1'b0;
    else if (tick) pending <= 1'b1;
    else if (ack)  pending <= 1'b0;
  end
endmodule

// File: rtl/sdc_read_return.sv
module sdc_read_return #(
  parameter int CAS_LAT = 3,
  parameter int DW      = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          issue,
  input  logic [DW-1:0] dq_in,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_data
);
  logic [CAS_LAT-1:0] pipe;

  generate
    if (CAS_LAT == 1) begin : g_short
      always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= issue;
      end
    end else begin : g_shift
      always_ff @(posedge clk) begin
        if (!rst_n) pipe <= '0;
        else        pipe <= {pipe[CAS_LAT-2:0], issue};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      rsp_valid <= pipe[CAS_LAT-1];
      if (pipe[CAS_LAT-1]) rsp_data <= dq_in;
    end
  end
endmodule

// File: rtl/sdc_ctrl.sv
module sdc_ctrl
  import sdc_pkg::*;
#(
  parameter int BANK_W       = 2,
  parameter int ROW_W        = 12,
  parameter int COL_W        = 8,
  parameter int DATA_W       = 32,
  parameter int CAS_LAT      = 3,
  parameter int T_RCD        = 2,
  parameter int T_RP         = 2,
  parameter int T_RAS        = 5,
  parameter int T_RC         = 7,
  parameter int T_RFC        = 7,
  parameter int T_MRD        = 2,
  parameter int T_WR         = 1,
  parameter int INIT_WAIT    = 20000,
  parameter int REF_INTERVAL = 1560,
  localparam int HOST_AW     = BANK_W + ROW_W + COL_W,
  localparam int NBYTE       = DATA_W / 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [HOST_AW-1:0] req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  input  logic [NBYTE-1:0]   req_be,
  output logic               rsp_valid,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic               init_done,
  output logic               sd_cs_n,
  output logic               sd_ras_n,
  output logic               sd_cas_n,
  output logic               sd_we_n,
  output logic [BANK_W-1:0]  sd_ba,
  output logic [ROW_W-1:0]   sd_addr,
  output logic [NBYTE-1:0]   sd_dqm,
  output logic [DATA_W-1:0]  sd_dq_out,
  output logic               sd_dq_oe,
  input  logic [DATA_W-1:0]  sd_dq_in
);
  localparam int RD_GAP  = access_gap(T_RC, T_RCD, T_RAS, T_RP, T_WR, CAS_LAT, 1'b0);
  localparam int WR_GAP  = access_gap(T_RC, T_RCD, T_RAS, T_RP, T_WR, CAS_LAT, 1'b1);
  localparam int GAP_MAX = imax(imax(INIT_WAIT, T_RFC), imax(imax(RD_GAP, WR_GAP),
                                imax(T_RP, imax(T_RCD, T_MRD))));
  localparam int GAP_W   = $clog2(GAP_MAX + 1);

  sdc_state_e state, state_n;
  sdc_cmd_e   cmd_n;
  logic [ROW_W-1:0]  addr_n;
  logic [BANK_W-1:0] ba_n;
  logic [NBYTE-1:0]  dqm_n;
  logic              oe_n;
  logic              gap_load;
  logic [GAP_W-1:0]  gap_val;
  logic              done_n;

  // named internal events
  logic gap_zero;
  logic ref_pending;
  logic ref_ack;
  logic accept;
  logic rd_issue;

  // latched request
  logic              lat_we;
  logic [BANK_W-1:0] lat_bank;
  logic [ROW_W-1:0]  lat_row;
  logic [COL_W-1:0]  lat_col;
  logic [DATA_W-1:0] lat_wdata;
  logic [NBYTE-1:0]  lat_be;

  sdc_gap_timer #(.W(GAP_W), .RST_VAL(INIT_WAIT - 1)) u_gap (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (gap_load),
    .load_val (gap_val),
    .zero     (gap_zero)
  );

  sdc_refresh_sched #(.INTERVAL(REF_INTERVAL)) u_ref (
    .clk     (clk),
    .rst_n   (rst_n),
    .enable  (init_done),
    .ack     (ref_ack),
    .pending (ref_pending)
  );

  sdc_read_return #(.CAS_LAT(CAS_LAT), .DW(DATA_W)) u_rret (
    .clk       (clk),
    .rst_n     (rst_n),
    .issue     (rd_issue),
    .dq_in     (sd_dq_in),
    .rsp_valid (rsp_valid),
    .rsp_data  (rsp_rdata)
  );

  assign req_ready = (state == ST_IDLE) && gap_zero && !ref_pending;
  assign accept    = req_ready && req_valid;

  always_comb begin
    state_n  = state;
    cmd_n    = CMD_NOP;
    addr_n   = '0;
    ba_n     = '0;
    dqm_n    = '1;
    oe_n     = 1'b0;
    gap_load = 1'b0;
    gap_val  = '0;
    ref_ack  = 1'b0;
    rd_issue = 1'b0;
    done_n   = init_done;
    if (gap_zero) begin
      unique case (state)
        ST_POWER: begin
          cmd_n      = CMD_PRE;
          addr_n[10] = 1'b1;
          gap_load   = 1'b1;
          gap_val    = GAP_W'(T_RP - 1);
          state_n    = ST_REF_A;
        end
        ST_REF_A: begin
          cmd_n    = CMD_REF;
          gap_load = 1'b1;
          gap_val  = GAP_W'(T_RFC - 1);
          state_n  = ST_REF_B;
        end
        ST_REF_B: begin
          cmd_n    = CMD_REF;
          gap_load = 1'b1;
          gap_val  = GAP_W'(T_RFC - 1);
          state_n  = ST_MODE;
        end
        ST_MODE: begin
          cmd_n    = CMD_MRS;
          addr_n   = ROW_W'(mode_word(CAS_LAT));
          gap_load = 1'b1;
          gap_val  = GAP_W'(T_MRD - 1);
          done_n   = 1'b1;
          state_n  = ST_IDLE;
        end
        ST_IDLE: begin
          if (ref_pending) begin
            cmd_n    = CMD_REF;
            ref_ack  = 1'b1;
            gap_load = 1'b1;
            gap_val  = GAP_W'(T_RFC - 1);
          end else if (req_valid) begin
            cmd_n    = CMD_ACT;
            addr_n   = req_addr[COL_W +: ROW_W];
            ba_n     = req_addr[COL_W + ROW_W +: BANK_W];
            gap_load = 1'b1;
            gap_val  = GAP_W'(T_RCD - 1);
            state_n  = ST_ACCESS;
          end
        end
        ST_ACCESS: begin
          cmd_n              = lat_we ? CMD_WR : CMD_RD;
          addr_n[COL_W-1:0]  = lat_col;
          addr_n[10]         = 1'b1;
          ba_n               = lat_bank;
          dqm_n              = lat_we ? ~lat_be : '0;
          oe_n               = lat_we;
          rd_issue           = !lat_we;
          gap_load           = 1'b1;
          gap_val            = lat_we ? GAP_W'(WR_GAP - 1) : GAP_W'(RD_GAP - 1);
          state_n            = ST_IDLE;
        end
        default: state_n = ST_POWER;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= ST_POWER;
      init_done <= 1'b0;
      {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} <= CMD_NOP;
      sd_addr   <= '0;
      sd_ba     <= '0;
      sd_dqm    <= '1;
      sd_dq_oe  <= 1'b0;
      sd_dq_out <= '0;
    end else begin
      state     <= state_n;
      init_done <= done_n;
      {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} <= cmd_n;
      sd_addr   <= addr_n;
      sd_ba     <= ba_n;
      sd_dqm    <= dqm_n;
      sd_dq_oe  <= oe_n;
      if (oe_n) sd_dq_out <= lat_wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lat_we    <= 1'b0;
      lat_bank  <= '0;
      lat_row   <= '0;
      lat_col   <= '0;
      lat_wdata <= '0;
      lat_be    <= '0;
    end else if (accept) begin
      lat_we    <= req_write;
      lat_col   <= req_addr[COL_W-1:0];
      lat_row   <= req_addr[COL_W +: ROW_W];
      lat_bank  <= req_addr[COL_W + ROW_W +: BANK_W];
      lat_wdata <= req_wdata;
      lat_be    <= req_be;
    end
  end

  logic unused_row;
  assign unused_row = ^lat_row;
endmodule

// File: rtl/sdc_ctrl_chk.sv
module sdc_ctrl_chk
  import sdc_pkg::*;
#(
  parameter int T_RCD = 2,
  parameter int T_RC  = 7,
  parameter int T_RFC = 7,
  parameter int GAP   = 5
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_ready,
  input logic       init_done,
  input logic       rsp_valid,
  input logic [3:0] cmd,
  input logic       a10,
  input logic       dq_oe,
  input logic       ref_pending
);
  localparam logic [7:0] SAT = 8'hFF;
  localparam int WAIT_MAX = ref_wait_bound(T_RFC, T_RCD, GAP);

  logic [7:0] since_act, since_ref, pend_cyc;
  logic is_act, is_rw, is_ref, is_cmd;

  assign is_act = (cmd == CMD_ACT);
  assign is_ref = (cmd == CMD_REF);
  assign is_rw  = (cmd == CMD_WR) || (cmd == CMD_RD);
  assign is_cmd = !cmd[3] && (cmd != CMD_NOP);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      since_act <= SAT;
      since_ref <= SAT;
      pend_cyc  <= '0;
    end else begin
      since_act <= is_act ? 8'd1 : ((since_act != SAT) ? since_act + 8'd1 : SAT);
      since_ref <= is_ref ? 8'd1 : ((since_ref != SAT) ? since_ref + 8'd1 : SAT);
      pend_cyc  <= !ref_pending ? 8'd0 : ((pend_cyc != SAT) ? pend_cyc + 8'd1 : SAT);
    end
  end

  // R1
  ready_after_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> init_done);
  // R7
  auto_pre_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_rw |-> a10);
  // R6
  rcd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_rw |-> (since_act >= 8'(T_RCD)));
  // R8
  rc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |-> (since_act >= 8'(T_RC)));
  // R8
  rfc_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    is_cmd |-> (since_ref >= 8'(T_RFC)));
  // R9
  oe_only_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (cmd == CMD_WR));
  // R10
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid);
  // R11
  ref_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pend_cyc <= 8'(WAIT_MAX));
endmodule

bind sdc_ctrl sdc_ctrl_chk #(
  .T_RCD (T_RCD),
  .T_RC  (T_RC),
  .T_RFC (T_RFC),
  .GAP   (sdc_pkg::imax(RD_GAP, WR_GAP))
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .req_ready   (req_ready),
  .init_done   (init_done),
  .rsp_valid   (rsp_valid),
  .cmd         ({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}),
  .a10         (sd_addr[10]),
  .dq_oe       (sd_dq_oe),
  .ref_pending (ref_pending)
);

// File: tb/sim_sdc_ctrl.sv
module sim_sdc_ctrl;
  localparam int CL     = 3;
  localparam int TRCD   = 2;
  localparam int TRP    = 2;
  localparam int TRC    = 7;
  localparam int TRFC   = 7;
  localparam int TMRD   = 2;
  localparam int IWAIT  = 12;
  localparam int RINT   = 150;
  localparam int SLACK  = 18;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [21:0] req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic [3:0]  req_be = '0;
  logic req_ready, rsp_valid, init_done;
  logic [31:0] rsp_rdata;
  logic sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [1:0]  sd_ba;
  logic [11:0] sd_addr;
  logic [3:0]  sd_dqm;
  logic [31:0] sd_dq_out;
  logic [31:0] sd_dq_in = '0;

  always #2 clk = ~clk;

  sdc_ctrl #(.CAS_LAT(CL), .T_RCD(TRCD), .T_RP(TRP), .T_RC(TRC), .T_RFC(TRFC),
             .T_MRD(TMRD), .INIT_WAIT(IWAIT), .REF_INTERVAL(RINT)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata), .req_be(req_be),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .init_done(init_done),
    .sd_cs_n(sd_cs_n), .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_ba(sd_ba), .sd_addr(sd_addr), .sd_dqm(sd_dqm), .sd_dq_out(sd_dq_out),
    .sd_dq_oe(sd_dq_oe), .sd_dq_in(sd_dq_in));

  typedef struct { bit we; logic [21:0] a; logic [31:0] d; logic [3:0] be; } req_t;

  int n_chk = 0, n_fail = 0, n = 0, rel_n = 0;
  bit finished = 0;
  int init_step = 0, last_pre = -1000, last_ref = -1000, last_mrs = -1000;
  int last_act = -1000, last_ref_op = 0, ref_ops = 0, ref_over_req = 0;
  req_t exp_req[$];
  req_t cur;
  logic [1:0]  act_ba;
  logic [11:0] act_row;
  logic [31:0] mem [int];
  logic [31:0] shadow [int];
  int drv_due[$], rsp_due[$];
  logic [31:0] drv_dat[$], rsp_dat[$];

  always @(posedge clk) n <= n + 1;

  task automatic chk(bit ok, string tag, string what, longint act, longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  // reference device and bus model, compared every clock
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      logic [3:0] c;
      int key;
      c = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};
      if (rsp_due.size() > 0 && rsp_due[0] == n) begin
        chk(rsp_valid === 1'b1, "R10", "rsp_valid at CAS latency", rsp_valid, 1);
        chk(rsp_rdata === rsp_dat[0], "R10", "read data", rsp_rdata, rsp_dat[0]);
        void'(rsp_due.pop_front());
        void'(rsp_dat.pop_front());
      end else if (rsp_valid !== 1'b0) begin
        chk(1'b0, "R10", "stray rsp_valid", rsp_valid, 0);
      end
      if (drv_due.size() > 0 && drv_due[0] == n) begin
        sd_dq_in = drv_dat.pop_front();
        void'(drv_due.pop_front());
      end
      if (init_step < 4 && req_ready) chk(1'b0, "R1", "ready during init", 1, 0);
      case (c)
        4'b0010: begin
          chk(init_step == 0, "R3", "precharge order", init_step, 0);
          chk(sd_addr[10] == 1'b1, "R2", "precharge all flag", sd_addr[10], 1);
          chk(n - rel_n >= IWAIT, "R2", "power-up wait", n - rel_n, IWAIT);
          init_step = 1; last_pre = n;
        end
        4'b0001: begin
          if (init_step == 1) begin
            chk(n - last_pre >= TRP, "R3", "tRP after precharge", n - last_pre, TRP);
            init_step = 2;
          end else if (init_step == 2) begin
            chk(n - last_ref >= TRFC, "R3", "tRFC between init refreshes", n - last_ref, TRFC);
            init_step = 3;
          end else if (init_step == 4) begin
            chk(n - last_ref_op >= RINT - SLACK && n - last_ref_op <= RINT + SLACK,
                "R11", "refresh spacing", n - last_ref_op, RINT);
            last_ref_op = n; ref_ops++;
            if (req_valid) ref_over_req++;
          end else chk(1'b0, "R3", "refresh out of order", init_step, 4);
          last_ref = n;
        end
        4'b0000: begin
          chk(init_step == 3, "R3", "mode set order", init_step, 3);
          chk(n - last_ref >= TRFC, "R3", "tRFC before mode set", n - last_ref, TRFC);
          chk(sd_addr == 12'h230, "R4", "mode word", sd_addr, 12'h230);
          chk(sd_ba == 2'b00, "R4", "mode bank bits", sd_ba, 0);
          init_step = 4; last_mrs = n; last_ref_op = n;
        end
        4'b0011: begin
          chk(init_step == 4, "R5", "activate before init", init_step, 4);
          chk(init_done === 1'b1, "R5", "init_done", init_done, 1);
          chk(n - last_mrs >= TMRD, "R5", "tMRD", n - last_mrs, TMRD);
          chk(n - last_act >= TRC, "R8", "tRC", n - last_act, TRC);
          chk(n - last_ref >= TRFC, "R8", "tRFC before activate", n - last_ref, TRFC);
          chk(exp_req.size() > 0, "R12", "activate without request", exp_req.size(), 1);
          if (exp_req.size() > 0) begin
            cur = exp_req.pop_front();
            chk(sd_ba == cur.a[21:20], "R6", "activate bank", sd_ba, cur.a[21:20]);
            chk(sd_addr == cur.a[19:8], "R6", "activate row", sd_addr, cur.a[19:8]);
          end
          act_ba = sd_ba; act_row = sd_addr; last_act = n;
        end
        4'b0100, 4'b0101: begin
          chk(n - last_act >= TRCD, "R6", "tRCD", n - last_act, TRCD);
          chk(sd_addr[10] == 1'b1, "R7", "auto-precharge flag", sd_addr[10], 1);
          chk(sd_addr[7:0] == cur.a[7:0], "R7", "column", sd_addr[7:0], cur.a[7:0]);
          chk(sd_ba == act_ba, "R7", "column bank", sd_ba, act_ba);
          chk((c == 4'b0100) == cur.we, "R12", "access kind", c, cur.we ? 4 : 5);
          key = int'({act_ba, act_row, sd_addr[7:0]});
          if (c == 4'b0100) begin
            logic [31:0] v;
            chk(sd_dq_oe === 1'b1, "R9", "write oe", sd_dq_oe, 1);
            chk(sd_dqm == ~cur.be, "R9", "write masks", sd_dqm, ~cur.be);
            chk(sd_dq_out == cur.d, "R9", "write data", sd_dq_out, cur.d);
            v = mem.exists(key) ? mem[key] : 32'h0;
            for (int b = 0; b < 4; b++) if (!sd_dqm[b]) v[8*b +: 8] = sd_dq_out[8*b +: 8];
            mem[key] = v;
          end else begin
            chk(sd_dq_oe === 1'b0, "R9", "read oe", sd_dq_oe, 0);
            drv_due.push_back(n + CL - 1);
            drv_dat.push_back(mem.exists(key) ? mem[key] : 32'h0);
            rsp_due.push_back(n + CL);
          end
        end
        4'b0111: ;
        default: chk(1'b0, "R3", "unexpected command", c, 7);
      endcase
    end
  end

  task automatic host_req(bit we, logic [21:0] a, logic [31:0] d, logic [3:0] be);
    req_t r;
    req_valid = 1'b1; req_write = we; req_addr = a; req_wdata = d; req_be = be;
    do @(negedge clk); while (!req_ready);
    r.we = we; r.a = a; r.d = d; r.be = be;
    exp_req.push_back(r);
    if (we) begin
      logic [31:0] v;
      v = shadow.exists(int'(a)) ? shadow[int'(a)] : 32'h0;
      for (int b = 0; b < 4; b++) if (be[b]) v[8*b +: 8] = d[8*b +: 8];
      shadow[int'(a)] = v;
    end else begin
      rsp_dat.push_back(shadow.exists(int'(a)) ? shadow[int'(a)] : 32'h0);
    end
    @(posedge clk); #1;
  endtask

  initial begin
    logic [31:0] lcg;
    lcg = 32'h1234_5678;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk({sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} == 4'b0111, "R1", "reset command NOP",
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 7);
    chk(req_ready === 1'b0, "R1", "reset ready", req_ready, 0);
    chk(rsp_valid === 1'b0, "R1", "reset rsp_valid", rsp_valid, 0);
    chk(init_done === 1'b0, "R1", "reset init_done", init_done, 0);
    rst_n = 1'b1; rel_n = n;
    while (!init_done) @(negedge clk);
    @(posedge clk); #1;
    // basic write and read back, bank 1
    host_req(1'b1, {2'd1, 12'h005, 8'h03}, 32'hDEAD_BEEF, 4'hF);
    host_req(1'b0, {2'd1, 12'h005, 8'h03}, 32'h0, 4'h0);
    // partial byte write, bank 2
    host_req(1'b1, {2'd2, 12'hABC, 8'hF0}, 32'hFFFF_FFFF, 4'hF);
    host_req(1'b1, {2'd2, 12'hABC, 8'hF0}, 32'h1234_5678, 4'b0101);
    host_req(1'b0, {2'd2, 12'hABC, 8'hF0}, 32'h0, 4'h0);
    // unwritten location, bank 3
    host_req(1'b0, {2'd3, 12'hFFF, 8'hFF}, 32'h0, 4'h0);
    req_valid = 1'b0;
    repeat (400) @(posedge clk);
    #1;
    // continuous mixed traffic across refresh intervals
    for (int i = 0; i < 70; i++) begin
      logic [3:0] idx;
      lcg = lcg * 32'd1103515245 + 32'd12345;
      idx = lcg[19:16];
      host_req(lcg[24], {idx[1:0], {10'd0, idx[3:2]}, {4'd0, idx}}, lcg ^ 32'h5A5A_A5A5, lcg[11:8]);
    end
    req_valid = 1'b0;
    repeat (40) @(posedge clk);
    @(negedge clk);
    chk(ref_ops >= 4, "R11", "refresh count", ref_ops, 4);
    chk(ref_over_req >= 1, "R11", "refresh beats waiting request", ref_over_req, 1);
    chk(exp_req.size() == 0, "R12", "requests left unserved", exp_req.size(), 0);
    chk(rsp_due.size() == 0 && rsp_dat.size() == 0, "R10", "missing responses",
        rsp_dat.size(), 0);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule